// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a host bus and the write/erase machinery of a flash memory controller. Each host bus write carries an address and a data word. The block decodes a run of such writes into setup and confirm phases and starts operations on a timed program/erase engine. For every command it also sets the source that a host read returns: the array, the status register, the signature data or the query data. It keeps a status register with a ready flag, suspend flags and error flags. The error flags stay set until the host clears them.

The engine is modelled as a countdown timer with a configurable busy time. It can be frozen and thawed, and it reports a fault at completion when the program voltage was absent at start. A second engine instance serves a program that the host issues while an erase is suspended. The block also accepts a buffer program. It takes a word count written as N-1, then N data writes, then a confirm. Address bits above `BLK_OFS_W` identify the block.

Top module: `fcmd_top`

## Requirements
- R1: After reset, `rd_sel` is 0 (array), `status` is 8'h80 and `op_start` is low.
- R2: In the idle state, command byte FFh sets `rd_sel`=0 (array), 70h sets 1 (status), 90h sets 2 (signature) and 98h sets 3 (query). Clear-status is 50h; it leaves `rd_sel` unchanged.
- R3: 40h or 10h, then one write, starts a single-word program. On the cycle after that write, `op_start` pulses with `op_kind`=0 and carries that write's address and data, `rd_sel` is 1, and `status[7]` is low for exactly `BUSY_CYC` cycles.
- R4: 20h followed by D0h starts an erase (`op_kind`=1) at the D0h write's address. Any other confirm byte sets `status[5]` and `status[4]`, starts nothing and leaves the block ready.
- R5: E8h at a start address, then a count C, then C+1 data writes, then D0h starts a buffer program with `op_kind`=2, `op_addr` equal to the start address and `op_len`=C+1. A count of C >= `BUF_MAX` sets `status[5:4]` and aborts.
- R6: C0h followed by one write starts a protection-word program (`op_kind`=3). 80h followed by D0h starts a factory program (`op_kind`=4) at the 80h write's address. A confirm other than D0h sets `status[5:4]`.
- R7: While an operation runs, only 70h, 98h and B0h have any effect. Every other write leaves `rd_sel` unchanged and starts nothing.
- R8: B0h during a run freezes the engine and sets `status[7]`, together with `status[6]` for an erase or `status[2]` for a program. D0h resumes the run, clears these bits, and the run completes in the cycles it had left.
- R9: While an erase is suspended, a program (40h/10h) to a different block starts at once on a second engine. A program to the suspended block sets `status[4]` and starts nothing.
- R10: Error bits `status[5:3]` and `status[1]` stay set until a 50h write in the idle or suspended state. While any of `status[5:3]` is set, a program or erase confirm starts nothing.
- R11: A program or erase whose start write sees `blk_locked` high starts nothing. It sets `status[1]`, plus `status[5]` for an erase or `status[4]` otherwise.
- R12: An operation started while `vpp_ok` is low still runs. At completion it sets `status[3]`, plus `status[5]` for an erase or `status[4]` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host bus write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Write address |
| bus_data | input | DATA_W | Write data; the low byte is the command code |
| blk_locked | input | 1 | The addressed block is write-protected |
| vpp_ok | input | 1 | Program voltage present |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 signature, 3 query |
| status | output | 8 | Status register |
| op_start | output | 1 | One-cycle pulse when an operation starts |
| op_kind | output | 3 | 0 program, 1 erase, 2 buffer, 3 protection word, 4 factory |
| op_addr | output | ADDR_W | Address of the started operation |
| op_data | output | DATA_W | Data of the write that started it |
| op_len | output | LEN_W | Word count of the started operation |

## Verification
The hardest state to reach is a program nested inside a suspended erase. Getting there needs an erase confirmed, then suspended after a known number of its busy cycles, then a clear of an error that a deliberate same-block program raised, and only then the program to a different block. The directed sequence does exactly this. It then resumes the erase and checks that the ready flag returns after only the cycles the erase had left before suspension. This shows the frozen count survived the nested run on the other engine.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_SIGN   = 2'd2,
        RD_QUERY  = 2'd3
    } rd_sel_e;

    typedef enum logic [2:0] {
        OP_PROG  = 3'd0,
        OP_ERASE = 3'd1,
        OP_BUF   = 3'd2,
        OP_OTP   = 3'd3,
        OP_FACT  = 3'd4
    } op_kind_e;

    typedef enum logic [3:0] {
        S_READY,
        S_PSETUP,
        S_ESETUP,
        S_BCOUNT,
        S_BDATA,
        S_BCONF,
        S_OSETUP,
        S_FSETUP,
        S_BUSY,
        S_SUSP,
        S_NSETUP,
        S_NBUSY
    } ci_state_e;

    // Error flags raised in one cycle; merged into the sticky register
    typedef struct packed {
        logic erase;
        logic prog;
        logic vpp;
        logic lock;
    } err_set_t;

    localparam logic [7:0] C_RD_ARRAY = 8'hFF;
    localparam logic [7:0] C_RD_STAT  = 8'h70;
    localparam logic [7:0] C_RD_SIGN  = 8'h90;
    localparam logic [7:0] C_RD_QUERY = 8'h98;
    localparam logic [7:0] C_CLR_STAT = 8'h50;
    localparam logic [7:0] C_ERASE    = 8'h20;
    localparam logic [7:0] C_CONFIRM  = 8'hD0;
    localparam logic [7:0] C_SUSPEND  = 8'hB0;
    localparam logic [7:0] C_BUFFER   = 8'hE8;
    localparam logic [7:0] C_OTP      = 8'hC0;
    localparam logic [7:0] C_FACTORY  = 8'h80;

    function automatic logic is_prog_cmd(input logic [7:0] c);
        return (c == 8'h40) || (c == 8'h10);
    endfunction

    // Read-mode commands allowed while the engine runs
    function automatic logic is_busy_read(input logic [7:0] c);
        return (c == C_RD_STAT) || (c == C_RD_QUERY);
    endfunction

endpackage

// File: rtl/fcmd_engine.sv
module fcmd_engine #(
    parameter int BUSY_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic hold,
    input  logic fail_in,
    output logic done,
    output logic fail
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             act_q;

    assign done = act_q && !hold && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= 1'b0;
            fail  <= 1'b0;
        end else if (start) begin
            cnt_q <= CNT_W'(BUSY_CYC);
            act_q <= 1'b1;
            fail  <= fail_in;
        end else if (done) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (act_q && !hold) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
    import fcmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ready,
    input  err_set_t set_err,
    input  logic     clr_err,
    input  logic     set_susp_e,
    input  logic     set_susp_p,
    input  logic     clr_susp,
    output logic [7:0] sr
);
    err_set_t err_q;
    logic     se_q, sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
            se_q  <= 1'b0;
            sp_q  <= 1'b0;
        end else begin
            err_q <= (clr_err ? '0 : err_q) | set_err;
            if (clr_susp) begin
                se_q <= 1'b0;
                sp_q <= 1'b0;
            end else begin
                se_q <= se_q | set_susp_e;
                sp_q <= sp_q | set_susp_p;
            end
        end
    end

    assign sr = {ready, se_q, err_q.erase, err_q.prog, err_q.vpp, sp_q, err_q.lock, 1'b0};
endmodule

// File: rtl/fcmd_top.sv
module fcmd_top
    import fcmd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int BLK_OFS_W = 8,
    parameter int BUSY_CYC  = 8,
    parameter int BUF_MAX   = 8,
    localparam int LEN_W    = $clog2(BUF_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              blk_locked,
    input  logic              vpp_ok,
    output logic [1:0]        rd_sel,
    output logic [7:0]        status,
    output logic              op_start,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [LEN_W-1:0]  op_len
);
    localparam int BLK_W   = ADDR_W - BLK_OFS_W;
    localparam int NUM_ENG = 2;

    ci_state_e         state_q, state_d;
    rd_sel_e           rd_q, rd_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [LEN_W-1:0]  left_q, left_d, len_q, len_d;
    logic [BLK_W-1:0]  susp_blk_q, susp_blk_d;
    logic              run_erase_q, run_erase_d;

    logic              launch, l_nested;
    op_kind_e          l_kind;
    logic [ADDR_W-1:0] l_addr;
    logic [LEN_W-1:0]  l_len;

    logic              op_v_d;
    op_kind_e          op_kind_q, op_kind_d;
    logic [ADDR_W-1:0] op_addr_d;
    logic [DATA_W-1:0] op_data_d;
    logic [LEN_W-1:0]  op_len_d;

    err_set_t          err_set;
    logic              clr_err, set_se, set_sp, clr_susp;
    logic [7:0]        sr_w;
    logic              err_pend, ready;

    logic [NUM_ENG-1:0] start_vec, hold_vec, eng_done, eng_fail;

    wire [7:0] cmd = bus_data[7:0];

    assign err_pend = sr_w[5] | sr_w[4] | sr_w[3];
    assign ready    = (state_q != S_BUSY) && (state_q != S_NBUSY);
    assign hold_vec = {1'b0, (state_q == S_SUSP) || (state_q == S_NSETUP) || (state_q == S_NBUSY)};

    // Engine 0 runs the main operation, engine 1 a program nested in an erase suspend
    for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
        fcmd_engine #(.BUSY_CYC(BUSY_CYC)) eng_i (
            .clk     (clk),
            .rst     (rst),
            .start   (start_vec[g]),
            .hold    (hold_vec[g]),
            .fail_in (!vpp_ok),
            .done    (eng_done[g]),
            .fail    (eng_fail[g])
        );
    end

    fcmd_status stat_i (
        .clk        (clk),
        .rst        (rst),
        .ready      (ready),
        .set_err    (err_set),
        .clr_err    (clr_err),
        .set_susp_e (set_se),
        .set_susp_p (set_sp),
        .clr_susp   (clr_susp),
        .sr         (sr_w)
    );

    always_comb begin
        state_d     = state_q;
        rd_d        = rd_q;
        base_d      = base_q;
        left_d      = left_q;
        len_d       = len_q;
        susp_blk_d  = susp_blk_q;
        run_erase_d = run_erase_q;
        launch      = 1'b0;
        l_nested    = 1'b0;
        l_kind      = OP_PROG;
        l_addr      = bus_addr;
        l_len       = LEN_W'(1);
        op_v_d      = 1'b0;
        op_kind_d   = op_kind_q;
        op_addr_d   = op_addr;
        op_data_d   = op_data;
        op_len_d    = op_len;
        err_set     = '0;
        clr_err     = 1'b0;
        set_se      = 1'b0;
        set_sp      = 1'b0;
        clr_susp    = 1'b0;
        start_vec   = '0;

        case (state_q)
            S_READY: if (bus_we) begin
                if (is_prog_cmd(cmd)) begin
                    state_d = S_PSETUP;
                    rd_d    = RD_STATUS;
                end else begin
                    case (cmd)
                        C_RD_ARRAY: rd_d = RD_ARRAY;
                        C_RD_STAT:  rd_d = RD_STATUS;
                        C_RD_SIGN:  rd_d = RD_SIGN;
                        C_RD_QUERY: rd_d = RD_QUERY;
                        C_CLR_STAT: clr_err = 1'b1;
                        C_ERASE: begin
                            state_d = S_ESETUP;
                            rd_d    = RD_STATUS;
                        end
                        C_BUFFER: begin
                            state_d = S_BCOUNT;
                            rd_d    = RD_STATUS;
                            base_d  = bus_addr;
                        end
                        C_OTP: begin
                            state_d = S_OSETUP;
                            rd_d    = RD_STATUS;
                        end
                        C_FACTORY: begin
                            state_d = S_FSETUP;
                            rd_d    = RD_STATUS;
                            base_d  = bus_addr;
                        end
                        default: ;
                    endcase
                end
            end
            S_PSETUP: if (bus_we) begin
                launch = 1'b1;
                l_kind = OP_PROG;
            end
            S_OSETUP: if (bus_we) begin
                launch = 1'b1;
                l_kind = OP_OTP;
            end
            S_ESETUP: if (bus_we) begin
                if (cmd == C_CONFIRM) begin
                    launch = 1'b1;
                    l_kind = OP_ERASE;
                end else begin
                    err_set.erase = 1'b1;
                    err_set.prog  = 1'b1;
                    state_d       = S_READY;
                end
            end
            S_BCOUNT: if (bus_we) begin
                if (bus_data >= DATA_W'(BUF_MAX)) begin
                    err_set.erase = 1'b1;
                    err_set.prog  = 1'b1;
                    state_d       = S_READY;
                end else begin
                    left_d  = LEN_W'(bus_data);
                    len_d   = LEN_W'(bus_data) + LEN_W'(1);
                    state_d = S_BDATA;
                end
            end
            S_BDATA: if (bus_we) begin
                if (left_q == '0) state_d = S_BCONF;
                else              left_d  = left_q - LEN_W'(1);
            end
            S_BCONF, S_FSETUP: if (bus_we) begin
                if (cmd == C_CONFIRM) begin
                    launch = 1'b1;
                    l_kind = (state_q == S_BCONF) ? OP_BUF : OP_FACT;
                    l_addr = base_q;
                    l_len  = (state_q == S_BCONF) ? len_q : LEN_W'(1);
                end else begin
                    err_set.erase = 1'b1;
                    err_set.prog  = 1'b1;
                    state_d       = S_READY;
                end
            end
            S_BUSY: begin
                if (eng_done[0]) begin
                    state_d = S_READY;
                    if (eng_fail[0]) begin
                        err_set.vpp   = 1'b1;
                        err_set.erase = run_erase_q;
                        err_set.prog  = !run_erase_q;
                    end
                end else if (bus_we) begin
                    if (cmd == C_RD_STAT)  rd_d = RD_STATUS;
                    if (cmd == C_RD_QUERY) rd_d = RD_QUERY;
                    if (cmd == C_SUSPEND) begin
                        state_d = S_SUSP;
                        rd_d    = RD_STATUS;
                        set_se  = run_erase_q;
                        set_sp  = !run_erase_q;
                    end
                end
            end
            S_SUSP: if (bus_we) begin
                if (is_prog_cmd(cmd)) begin
                    if (sr_w[6]) begin
                        state_d = S_NSETUP;
                        rd_d    = RD_STATUS;
                    end
                end else begin
                    case (cmd)
                        C_RD_ARRAY: rd_d = RD_ARRAY;
                        C_RD_STAT:  rd_d = RD_STATUS;
                        C_RD_SIGN:  rd_d = RD_SIGN;
                        C_RD_QUERY: rd_d = RD_QUERY;
                        C_CLR_STAT: clr_err = 1'b1;
                        C_CONFIRM: begin
                            state_d  = S_BUSY;
                            rd_d     = RD_STATUS;
                            clr_susp = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            S_NSETUP: if (bus_we) begin
                if (bus_addr[ADDR_W-1:BLK_OFS_W] == susp_blk_q) begin
                    err_set.prog = 1'b1;
                    state_d      = S_SUSP;
                end else begin
                    launch   = 1'b1;
                    l_nested = 1'b1;
                    l_kind   = OP_PROG;
                end
            end
            S_NBUSY: begin
                if (eng_done[1]) begin
                    state_d = S_SUSP;
                    if (eng_fail[1]) begin
                        err_set.vpp  = 1'b1;
                        err_set.prog = 1'b1;
                    end
                end else if (bus_we) begin
                    if (cmd == C_RD_STAT)  rd_d = RD_STATUS;
                    if (cmd == C_RD_QUERY) rd_d = RD_QUERY;
                end
            end
            default: state_d = S_READY;
        endcase

        // Common start path: pending error, lock check, then engine start
        if (launch) begin
            if (err_pend) begin
                state_d = l_nested ? S_SUSP : S_READY;
            end else if (blk_locked) begin
                err_set.lock = 1'b1;
                if (l_kind == OP_ERASE) err_set.erase = 1'b1;
                else                    err_set.prog  = 1'b1;
                state_d = l_nested ? S_SUSP : S_READY;
            end else begin
                start_vec[l_nested ? 1 : 0] = 1'b1;
                state_d   = l_nested ? S_NBUSY : S_BUSY;
                op_v_d    = 1'b1;
                op_kind_d = l_kind;
                op_addr_d = l_addr;
                op_data_d = bus_data;
                op_len_d  = l_len;
                if (!l_nested) begin
                    run_erase_d = (l_kind == OP_ERASE);
                    susp_blk_d  = l_addr[ADDR_W-1:BLK_OFS_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_READY;
            rd_q        <= RD_ARRAY;
            base_q      <= '0;
            left_q      <= '0;
            len_q       <= '0;
            susp_blk_q  <= '0;
            run_erase_q <= 1'b0;
            op_start    <= 1'b0;
            op_kind_q   <= OP_PROG;
            op_addr     <= '0;
            op_data     <= '0;
            op_len      <= '0;
        end else begin
            state_q     <= state_d;
            rd_q        <= rd_d;
            base_q      <= base_d;
            left_q      <= left_d;
            len_q       <= len_d;
            susp_blk_q  <= susp_blk_d;
            run_erase_q <= run_erase_d;
            op_start    <= op_v_d;
            op_kind_q   <= op_kind_d;
            op_addr     <= op_addr_d;
            op_data     <= op_data_d;
            op_len      <= op_len_d;
        end
    end

    assign rd_sel  = rd_q;
    assign op_kind = op_kind_q;
    assign status  = sr_w;
endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_data,
    input logic [1:0]        rd_sel,
    input logic [7:0]        status,
    input logic              op_start
);
    wire [7:0] c = bus_data[7:0];

    // R3: a started operation shows busy and status reads in the same cycle
    assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
        op_start |-> (!status[7] && rd_sel == 2'd1));

    // R3: the start indication is a single-cycle pulse
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        op_start |=> !op_start);

    // R7: writes other than status read, query read or suspend are ignored while busy
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !status[7] && c != 8'h70 && c != 8'h98 && c != 8'hB0)
        |=> ($stable(rd_sel) && !op_start));

    // R8: at most one suspend flag is set at a time
    assert_one_susp_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({status[6], status[2]}));

    // R8: a suspended program always reports ready
    assert_psusp_ready_R8: assert property (@(posedge clk) disable iff (rst)
        status[2] |-> status[7]);

    // R10: program error bit is sticky unless a clear command is written
    assert_sticky_prog_R10: assert property (@(posedge clk) disable iff (rst)
        (status[4] && !(bus_we && c == 8'h50)) |=> status[4]);

    // R10: erase error bit is sticky unless a clear command is written
    assert_sticky_erase_R10: assert property (@(posedge clk) disable iff (rst)
        (status[5] && !(bus_we && c == 8'h50)) |=> status[5]);
endmodule

bind fcmd_top fcmd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_data (bus_data),
    .rd_sel   (rd_sel),
    .status   (status),
    .op_start (op_start)
);

// File: tb/fcmd_top_tb_top.sv
module fcmd_top_tb_top;
    localparam int BUSY = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        blk_locked = 1'b0;
    logic        vpp_ok = 1'b1;
    logic [1:0]  rd_sel;
    logic [7:0]  status;
    logic        op_start;
    logic [2:0]  op_kind;
    logic [15:0] op_addr;
    logic [15:0] op_data;
    logic [3:0]  op_len;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fcmd_top #(.BUSY_CYC(BUSY)) dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_data(bus_data),
        .blk_locked(blk_locked), .vpp_ok(vpp_ok), .rd_sel(rd_sel), .status(status),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .op_len(op_len)
    );

    // Row: {data, addr, expected rd_sel, expected status}
    localparam int NV = 15;
    localparam logic [41:0] VEC [NV] = '{
        {16'h00FF, 16'h0000, 2'd0, 8'h80},  // R2 array
        {16'h0070, 16'h0000, 2'd1, 8'h80},  // R2 status
        {16'h0090, 16'h0000, 2'd2, 8'h80},  // R2 signature
        {16'h0098, 16'h0000, 2'd3, 8'h80},  // R2 query
        {16'h00FF, 16'h0000, 2'd0, 8'h80},  // R2 array again
        {16'h0020, 16'h0400, 2'd1, 8'h80},  // R4 erase setup
        {16'h0055, 16'h0400, 2'd1, 8'hB0},  // R4 bad confirm
        {16'h0050, 16'h0000, 2'd1, 8'h80},  // R10 clear
        {16'h00E8, 16'h0200, 2'd1, 8'h80},  // R5 buffer setup
        {16'h0009, 16'h0200, 2'd1, 8'hB0},  // R5 count too large
        {16'h0050, 16'h0000, 2'd1, 8'h80},  // R10 clear
        {16'h0080, 16'h0300, 2'd1, 8'h80},  // R6 factory setup
        {16'h0012, 16'h0300, 2'd1, 8'hB0},  // R6 bad confirm
        {16'h0050, 16'h0000, 2'd1, 8'h80},  // R10 clear
        {16'h00FF, 16'h0000, 2'd0, 8'h80}   // R2 array
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d, input logic [15:0] a);
        bus_we = 1'b1;
        bus_data = d;
        bus_addr = a;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R1 rd_sel", rd_sel, 0);
        check("R1 status", status, 8'h80);
        check("R1 op_start", op_start, 0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][41:26], VEC[i][25:10]);
            check($sformatf("R2/R4/R5/R6 vec%0d rd_sel", i), rd_sel, VEC[i][9:8]);
            check($sformatf("R2/R4/R5/R6 vec%0d status", i), status, VEC[i][7:0]);
            check($sformatf("R4/R5/R6 vec%0d no start", i), op_start, 0);
        end

        // R3 single-word program and exact busy time
        wr(16'h0040, 16'h0123);
        wr(16'hBEEF, 16'h0123);
        check("R3 op_start", op_start, 1);
        check("R3 op_kind", op_kind, 0);
        check("R3 op_addr", op_addr, 16'h0123);
        check("R3 op_data", op_data, 16'hBEEF);
        check("R3 rd_sel", rd_sel, 1);
        check("R3 busy", status[7], 0);
        tick(BUSY - 1);
        check("R3 busy last", status[7], 0);
        tick(1);
        check("R3 ready", status, 8'h80);

        // R7 busy ignores most commands
        wr(16'h0010, 16'h0124);
        wr(16'h1111, 16'h0124);
        check("R3 10h start", op_start, 1);
        wr(16'h00FF, 16'h0000);
        check("R7 FFh ignored", rd_sel, 1);
        wr(16'h0090, 16'h0000);
        check("R7 90h ignored", rd_sel, 1);
        wr(16'h0098, 16'h0000);
        check("R7 98h taken", rd_sel, 3);
        wr(16'h0020, 16'h0500);
        check("R7 20h ignored", rd_sel, 3);
        wr(16'h00D0, 16'h0500);
        check("R7 D0h no start", op_start, 0);
        tick(BUSY);
        check("R7 ready after", status, 8'h80);

        // R4 erase, R8 suspend, R9 nested program
        wr(16'h0020, 16'h0500);
        wr(16'h00D0, 16'h0500);
        check("R4 erase start", op_start, 1);
        check("R4 erase kind", op_kind, 1);
        check("R4 erase addr", op_addr, 16'h0500);
        tick(1);
        wr(16'h00B0, 16'h0000);
        check("R8 erase suspended", status, 8'hC0);
        tick(5);
        check("R8 frozen", status, 8'hC0);
        wr(16'h0040, 16'h0000);
        wr(16'h2222, 16'h0510);
        check("R9 same block rejected", status, 8'hD0);
        check("R9 same block no start", op_start, 0);
        wr(16'h0050, 16'h0000);
        check("R10 clear in suspend", status, 8'hC0);
        wr(16'h0040, 16'h0000);
        wr(16'h1234, 16'h0700);
        check("R9 nested start", op_start, 1);
        check("R9 nested addr", op_addr, 16'h0700);
        check("R9 nested busy", status, 8'h40);
        tick(BUSY);
        check("R9 nested done", status, 8'hC0);
        wr(16'h00D0, 16'h0000);
        check("R8 resumed", status, 8'h00);
        tick(BUSY - 3);
        check("R8 remaining busy", status[7], 0);
        tick(1);
        check("R8 erase complete", status, 8'h80);

        // R8 program suspend
        wr(16'h0040, 16'h0900);
        wr(16'h3333, 16'h0900);
        wr(16'h00B0, 16'h0000);
        check("R8 prog suspended", status, 8'h84);
        wr(16'h00D0, 16'h0000);
        check("R8 prog resumed", status, 8'h00);
        tick(BUSY);
        check("R8 prog complete", status, 8'h80);

        // R5 buffer program with count 3
        wr(16'h00E8, 16'h0200);
        wr(16'h0003, 16'h0200);
        for (int k = 0; k < 4; k++) wr(16'hA000 + 16'(k), 16'h0200 + 16'(k));
        check("R5 no early start", op_start, 0);
        wr(16'h00D0, 16'h0200);
        check("R5 start", op_start, 1);
        check("R5 kind", op_kind, 2);
        check("R5 addr", op_addr, 16'h0200);
        check("R5 len", op_len, 4);
        tick(BUSY);

        // R6 protection word and factory program
        wr(16'h00C0, 16'h0000);
        wr(16'hAA55, 16'h0081);
        check("R6 otp kind", op_kind, 3);
        check("R6 otp start", op_start, 1);
        tick(BUSY);
        wr(16'h0080, 16'h0300);
        wr(16'h00D0, 16'h0300);
        check("R6 factory kind", op_kind, 4);
        check("R6 factory addr", op_addr, 16'h0300);
        tick(BUSY);

        // R11 locked block, R10 pending error blocks new ops
        blk_locked = 1'b1;
        wr(16'h0020, 16'h0600);
        wr(16'h00D0, 16'h0600);
        check("R11 erase locked", status, 8'hA2);
        check("R11 no start", op_start, 0);
        blk_locked = 1'b0;
        wr(16'h0040, 16'h0700);
        wr(16'h4444, 16'h0700);
        check("R10 pending error no start", op_start, 0);
        check("R10 still sticky", status, 8'hA2);
        wr(16'h00FF, 16'h0000);
        check("R10 sticky after read cmd", status, 8'hA2);
        wr(16'h0050, 16'h0000);
        check("R10 cleared", status, 8'h80);

        // R12 program voltage missing
        vpp_ok = 1'b0;
        wr(16'h0040, 16'h0800);
        wr(16'h5555, 16'h0800);
        check("R12 still starts", op_start, 1);
        vpp_ok = 1'b1;
        tick(BUSY);
        check("R12 vpp error", status, 8'h98);
        wr(16'h0050, 16'h0000);
        check("R12 cleared", status, 8'h80);

        summary();
    end
endmodule